// File: doc/BRIEF.md
# Answer-to-Reset Window Monitor

This block supervises the card's answer to a cold or warm reset. The activation sequencer sends one start pulse once the card clock is running. The monitor then counts card clock ticks. Each start-bit detection reported by the I/O receiver is sorted by the tick count at which it arrives: too soon to matter, too early, or in time. If the card stays silent for a whole window while reset is low, the monitor raises the card reset line and gives the card a second window. Silence through that second window is reported as a mute card.

The outputs go to the status and control logic. Early and mute are one-cycle event pulses that a status register can latch. Done is a level that tells the rest of the interface the answer has begun and the tick count has stopped. After any outcome the monitor waits for the next start pulse. Character reception is handled elsewhere.

Top module: `atr_window_mon`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `card_rst_o`, `early_o`, `mute_o` and `done_o` are all 0, and the monitor is idle.
- R2: A `start_i` pulse in any state clears the tick count, drives `card_rst_o` low, clears `done_o`, and starts the reset-low phase on the next cycle. `start_i` takes priority over every other input in that cycle.
- R3: In the reset-low phase, a start bit that arrives while fewer than `IGNORE_TICKS` ticks have been counted is ignored, and counting continues.
- R4: In the reset-low phase, a start bit that arrives with at least `IGNORE_TICKS` and fewer than `EARLY_TICKS` ticks counted gives a one-cycle `early_o` pulse on the next cycle. The monitor then goes idle, and `card_rst_o` stays low.
- R5: In either phase, a start bit that arrives with at least `EARLY_TICKS` counted ticks sets `done_o` on the next cycle. `done_o` holds until the next `start_i`, counting stops, and `card_rst_o` keeps its value.
- R6: If the reset-low phase sees `TIMEOUT_TICKS` ticks without an accepted start bit, `card_rst_o` goes high on the cycle after the last tick. The reset-high phase then begins with a count of zero.
- R7: In the reset-high phase, a start bit that arrives with fewer than `EARLY_TICKS` ticks counted (there is no ignore zone) gives a one-cycle `early_o` pulse. The monitor then goes idle with `card_rst_o` still high.
- R8: If the reset-high phase sees `TIMEOUT_TICKS` ticks without a start bit, a one-cycle `mute_o` pulse follows. `card_rst_o` stays high and the monitor goes idle.
- R9: When a start bit and a tick arrive in the same cycle, the start bit is classified by the count before that tick.
- R10: While the monitor is idle or done, ticks and start bits cause no pulse and do not change `done_o` or `card_rst_o`. `early_o` and `mute_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle pulse: card clock started, begin monitoring |
| card_clk_tick_i | input | 1 | One-cycle pulse per card clock period |
| sbit_i | input | 1 | One-cycle pulse: start bit detected on the card I/O line |
| card_rst_o | output | 1 | Card reset line level (1 = reset released) |
| early_o | output | 1 | One-cycle event: answer came too early |
| mute_o | output | 1 | One-cycle event: no answer in the reset-high window |
| done_o | output | 1 | Level: answer accepted, count stopped |

## Verification
An off-by-one zone boundary in the count shows at the ports in the cycle right after a start bit placed exactly on that boundary. At that point an `early_o` pulse appears where none is due, or is missing where one is due. A phase register left in the wrong state shows as a missing or extra `card_rst_o` rise one cycle after the final tick of a window. A stale count carried into the reset-high phase shifts the `mute_o` pulse by the same number of ticks. So the bench puts start bits on both sides of each boundary and compares the outputs against a reference on every clock.

// File: rtl/atr_mon_pkg.sv
package atr_mon_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_RST_LO = 2'd1,
    PH_RST_HI = 2'd2
  } phase_e;

  typedef enum logic [1:0] {
    ZN_IGNORE = 2'd0,
    ZN_EARLY  = 2'd1,
    ZN_VALID  = 2'd2
  } zone_e;

endpackage

// File: rtl/atr_tick_counter.sv
module atr_tick_counter #(
  parameter int CNT_W = 16,
  parameter int LIMIT = 41950
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] count_o,
  output logic             last_o
);

  localparam logic [CNT_W-1:0] LastVal = CNT_W'(LIMIT - 1);

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      count_o <= '0;
    end else if (inc_i) begin
      count_o <= count_o + 1'b1;
    end
  end

  // the next tick completes the window
  assign last_o = (count_o == LastVal);

endmodule

// File: rtl/atr_zone_decode.sv
module atr_zone_decode
  import atr_mon_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int IGN_TICKS  = 200,
  parameter int EARLY_TICKS = 352
) (
  input  logic [CNT_W-1:0] count_i,
  input  logic             hi_phase_i,
  output zone_e            zone_o
);

  localparam logic [CNT_W-1:0] EarlyBound = CNT_W'(EARLY_TICKS);

  logic below_ign;

  generate
    if (IGN_TICKS > 0) begin : g_ign
      localparam logic [CNT_W-1:0] IgnBound = CNT_W'(IGN_TICKS);
      // the ignore zone exists only while reset is held low
      assign below_ign = !hi_phase_i && (count_i < IgnBound);
    end else begin : g_no_ign
      assign below_ign = 1'b0;
    end
  endgenerate

  always_comb begin
    if (below_ign) begin
      zone_o = ZN_IGNORE;
    end else if (count_i < EarlyBound) begin
      zone_o = ZN_EARLY;
    end else begin
      zone_o = ZN_VALID;
    end
  end

endmodule

// File: rtl/atr_phase_fsm.sv
module atr_phase_fsm
  import atr_mon_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   start_i,
  input  logic   tick_i,
  input  logic   sbit_i,
  input  zone_e  zone_i,
  input  logic   last_i,
  output phase_e phase_o,
  output logic   cnt_clr_o,
  output logic   cnt_inc_o,
  output logic   card_rst_o,
  output logic   early_o,
  output logic   mute_o,
  output logic   done_o
);

  phase_e phase_q, phase_d;
  logic   card_rst_d, done_d;
  logic   in_window, answer, early_hit, valid_hit, window_end;

  assign in_window  = (phase_q == PH_RST_LO) || (phase_q == PH_RST_HI);
  assign answer     = in_window && sbit_i && (zone_i != ZN_IGNORE);
  assign early_hit  = answer && (zone_i == ZN_EARLY);
  assign valid_hit  = answer && (zone_i == ZN_VALID);
  assign window_end = in_window && !answer && tick_i && last_i;

  assign cnt_clr_o = start_i || (window_end && (phase_q == PH_RST_LO));
  assign cnt_inc_o = in_window && !start_i && !answer && tick_i && !last_i;

  always_comb begin
    phase_d    = phase_q;
    card_rst_d = card_rst_o;
    done_d     = done_o;
    if (start_i) begin
      phase_d    = PH_RST_LO;
      card_rst_d = 1'b0;
      done_d     = 1'b0;
    end else if (answer) begin
      phase_d = PH_IDLE;
      done_d  = valid_hit;
    end else if (window_end) begin
      if (phase_q == PH_RST_LO) begin
        phase_d    = PH_RST_HI;
        card_rst_d = 1'b1;
      end else begin
        phase_d = PH_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q    <= PH_IDLE;
      card_rst_o <= 1'b0;
      done_o     <= 1'b0;
      early_o    <= 1'b0;
      mute_o     <= 1'b0;
    end else begin
      phase_q    <= phase_d;
      card_rst_o <= card_rst_d;
      done_o     <= done_d;
      early_o    <= !start_i && early_hit;
      mute_o     <= !start_i && window_end && (phase_q == PH_RST_HI);
    end
  end

  assign phase_o = phase_q;

endmodule

// File: rtl/atr_window_mon.sv
module atr_window_mon
  import atr_mon_pkg::*;
#(
  parameter int IGNORE_TICKS  = 200,
  parameter int EARLY_TICKS   = 352,
  parameter int TIMEOUT_TICKS = 41950
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic card_clk_tick_i,
  input  logic sbit_i,
  output logic card_rst_o,
  output logic early_o,
  output logic mute_o,
  output logic done_o
);

  localparam int NeedW = $clog2(TIMEOUT_TICKS + 1);
  localparam int CntW  = (NeedW < 16) ? 16 : NeedW;

  logic [CntW-1:0] count;
  logic            last, cnt_clr, cnt_inc;
  zone_e           zone;
  phase_e          phase;

  atr_tick_counter #(
    .CNT_W(CntW),
    .LIMIT(TIMEOUT_TICKS)
  ) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (cnt_clr),
    .inc_i  (cnt_inc),
    .count_o(count),
    .last_o (last)
  );

  atr_zone_decode #(
    .CNT_W      (CntW),
    .IGN_TICKS  (IGNORE_TICKS),
    .EARLY_TICKS(EARLY_TICKS)
  ) u_zone (
    .count_i   (count),
    .hi_phase_i(phase == PH_RST_HI),
    .zone_o    (zone)
  );

  atr_phase_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .tick_i    (card_clk_tick_i),
    .sbit_i    (sbit_i),
    .zone_i    (zone),
    .last_i    (last),
    .phase_o   (phase),
    .cnt_clr_o (cnt_clr),
    .cnt_inc_o (cnt_inc),
    .card_rst_o(card_rst_o),
    .early_o   (early_o),
    .mute_o    (mute_o),
    .done_o    (done_o)
  );

endmodule

// File: rtl/atr_window_mon_chk.sv
module atr_window_mon_chk (
  input logic clk,
  input logic rst,
  input logic start_i,
  input logic card_rst_o,
  input logic early_o,
  input logic mute_o,
  input logic done_o
);

  // R2
  start_clears_chk: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (!card_rst_o && !done_o && !early_o && !mute_o));

  // R8
  mute_with_rst_high_chk: assert property (@(posedge clk) disable iff (rst)
    mute_o |-> card_rst_o);

  // R4
  early_single_chk: assert property (@(posedge clk) disable iff (rst)
    early_o |=> !early_o);

  // R8
  mute_single_chk: assert property (@(posedge clk) disable iff (rst)
    mute_o |=> !mute_o);

  // R5
  done_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && !start_i) |=> done_o);

  // R10
  no_dual_event_chk: assert property (@(posedge clk) disable iff (rst)
    !(early_o && mute_o));

  // R4
  early_not_done_chk: assert property (@(posedge clk) disable iff (rst)
    early_o |-> !done_o);

  // R6
  rst_rise_clean_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(card_rst_o) |-> (!done_o && !early_o && !mute_o));

endmodule

bind atr_window_mon atr_window_mon_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .start_i   (start_i),
  .card_rst_o(card_rst_o),
  .early_o   (early_o),
  .mute_o    (mute_o),
  .done_o    (done_o)
);

// File: tb/atr_window_mon_bench.sv
`timescale 1ns/1ps
module atr_window_mon_bench;

  localparam int IGN = 20;
  localparam int ERL = 35;
  localparam int TO  = 400;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0, tick = 1'b0, sbit = 1'b0;
  logic card_rst_o, early_o, mute_o, done_o;

  int n_tests = 0, n_fail = 0, cycles = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  atr_window_mon #(
    .IGNORE_TICKS (IGN),
    .EARLY_TICKS  (ERL),
    .TIMEOUT_TICKS(TO)
  ) u_atr_window_mon (
    .clk(clk), .rst(rst), .start_i(start_i), .card_clk_tick_i(tick),
    .sbit_i(sbit), .card_rst_o(card_rst_o), .early_o(early_o),
    .mute_o(mute_o), .done_o(done_o)
  );

  // reference model: 0 idle, 1 reset-low window, 2 reset-high window
  int m_ph = 0, m_cnt = 0;
  bit m_rst = 0, m_early = 0, m_mute = 0, m_done = 0;

  always @(posedge clk) begin
    int lo;
    if (rst) begin
      m_ph = 0; m_cnt = 0; m_rst = 0; m_early = 0; m_mute = 0; m_done = 0;
    end else begin
      m_early = 0; m_mute = 0;
      if (start_i) begin
        m_ph = 1; m_cnt = 0; m_rst = 0; m_done = 0;
      end else if (m_ph != 0) begin
        lo = (m_ph == 1) ? IGN : 0;
        if (sbit && m_cnt >= lo) begin
          if (m_cnt < ERL) m_early = 1; else m_done = 1;
          m_ph = 0;
        end else if (tick) begin
          if (m_cnt == TO - 1) begin
            if (m_ph == 1) begin m_ph = 2; m_cnt = 0; m_rst = 1; end
            else begin m_mute = 1; m_ph = 0; end
          end else m_cnt++;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk(card_rst_o == m_rst, cur_req, "card_rst_o", card_rst_o, m_rst);
      chk(early_o == m_early, cur_req, "early_o", early_o, m_early);
      chk(mute_o == m_mute, cur_req, "mute_o", mute_o, m_mute);
      chk(done_o == m_done, cur_req, "done_o", done_o, m_done);
    end
  end

  task automatic cyc(input logic st, input logic sb, input logic tk);
    @(negedge clk);
    start_i = st; sbit = sb; tick = tk;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 1);
  endtask

  task automatic outs(input string req, input int r, input int e,
                      input int m, input int d);
    chk(card_rst_o == r, req, "card_rst_o", card_rst_o, r);
    chk(early_o == e, req, "early_o", early_o, e);
    chk(mute_o == m, req, "mute_o", mute_o, m);
    chk(done_o == d, req, "done_o", done_o, d);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    outs("R1", 0, 0, 0, 0);
    rst = 0;
    cyc(0, 0, 0);
    outs("R1", 0, 0, 0, 0);

    cur_req = "R10";
    cyc(0, 1, 1); cyc(0, 0, 0);
    outs("R10", 0, 0, 0, 0);

    cur_req = "R3";
    cyc(1, 0, 0); ticks(19); cyc(0, 1, 0); cyc(0, 0, 0);
    outs("R3", 0, 0, 0, 0);
    cur_req = "R4";
    ticks(1); cyc(0, 1, 0); cyc(0, 0, 0);
    outs("R4", 0, 1, 0, 0);
    cyc(0, 0, 0);
    outs("R4", 0, 0, 0, 0);

    cur_req = "R9";
    cyc(1, 0, 0); ticks(34); cyc(0, 1, 1); cyc(0, 0, 0);
    outs("R9", 0, 1, 0, 0);

    cur_req = "R5";
    cyc(1, 0, 0); ticks(35); cyc(0, 1, 0); cyc(0, 0, 0);
    outs("R5", 0, 0, 0, 1);
    cur_req = "R10";
    ticks(500); cyc(0, 1, 0); cyc(0, 0, 0);
    outs("R10", 0, 0, 0, 1);

    cur_req = "R6";
    cyc(1, 0, 0); ticks(399); cyc(0, 0, 0);
    outs("R6", 0, 0, 0, 0);
    ticks(1); cyc(0, 0, 0);
    outs("R6", 1, 0, 0, 0);
    cur_req = "R7";
    ticks(34); cyc(0, 1, 0); cyc(0, 0, 0);
    outs("R7", 1, 1, 0, 0);

    cur_req = "R5";
    cyc(1, 0, 0); ticks(400); ticks(35); cyc(0, 1, 0); cyc(0, 0, 0);
    outs("R5", 1, 0, 0, 1);

    cur_req = "R8";
    cyc(1, 0, 0); ticks(400); ticks(399); cyc(0, 0, 0);
    outs("R8", 1, 0, 0, 0);
    ticks(1); cyc(0, 0, 0);
    outs("R8", 1, 0, 1, 0);
    cyc(0, 0, 0);
    outs("R8", 1, 0, 0, 0);

    cur_req = "R2";
    cyc(1, 0, 0); ticks(400); ticks(5); cyc(1, 1, 1); cyc(0, 0, 0);
    outs("R2", 0, 0, 0, 0);
    cur_req = "R3";
    cyc(0, 1, 0); cyc(0, 0, 0);
    outs("R3", 0, 0, 0, 0);

    repeat (3) cyc(0, 0, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule